// File: doc/BRIEF.md
# Translation Prefetch Buffer

This block is a small per-core store for address translations that were prefetched on behalf of this core. Prefetched translations never go straight into the TLB. They wait here until the core misses in its TLB. On that miss the lookup port is probed. A matching entry is returned in the same cycle, handed to the refill path, and removed from the buffer on the next clock edge.

Every entry remembers which core initiated the prefetch, so the prefetch can be judged later. A hit reports that initiator as a useful prefetch, so its confidence can be raised. An entry pushed out by a newer insertion has never been consumed, because consuming it would have removed it. Its initiator is therefore reported as the source of a bad prefetch.

Insertions arrive on a valid/ready stream. `ins_ready` is low while reset is held and stays high from the first clock after reset. An insertion is accepted only on a cycle where both `ins_valid` and `ins_ready` are high, and the producer must hold its fields steady until then. The lookup port and the two feedback indications are plain single-cycle signals.

Top module: `xlat_pfbuf`

## Requirements
- R1: After reset the buffer is empty. No lookup hits, `bad_valid` is low, `ins_ready` is low while reset is held and high from the first clock after release.
- R2: A lookup hits only when an entry has equal virtual page number, context and page-size code. A difference in any one of the three gives a miss.
- R3: On a hit, `lk_hit`, `lk_ppn` and the initiating core `lk_core` are valid in the same cycle as the request.
- R4: A hit removes the entry at the next clock edge, so a repeated lookup of the same tag on the next cycle misses.
- R5: While `lk_valid` is low, `lk_hit` stays low and no entry is removed, whatever the lookup tag fields hold.
- R6: The buffer holds ENTRIES (16) translations. An insertion into a buffer with a free slot raises no bad-prefetch indication.
- R7: An accepted insertion with a new tag into a full buffer replaces the entry least recently inserted or refreshed. In that same cycle it pulses `bad_valid` with `bad_core` set to the victim's initiator.
- R8: An insertion whose tag equals a stored entry overwrites that entry's physical page and initiator, makes it the most recent for replacement order, and evicts nothing.
- R9: When a lookup hits in the same cycle as an accepted insertion, the slot being consumed counts as free. No eviction is reported. If both carry the same tag, the lookup returns the old contents and the inserted contents remain stored.
- R10: An insertion takes effect only when `ins_valid` and `ins_ready` are both high. Fields presented with `ins_valid` low are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insertion request valid |
| ins_ready | output | 1 | Buffer accepts insertions |
| ins_vpn | input | VPN_W | Virtual page number of inserted translation |
| ins_ctx | input | CTX_W | Context identifier of inserted translation |
| ins_size | input | SZ_W | Page-size code of inserted translation |
| ins_ppn | input | PPN_W | Physical page number of inserted translation |
| ins_core | input | CORE_W | Core that initiated the prefetch |
| lk_valid | input | 1 | Lookup request (TLB miss probe) |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_ctx | input | CTX_W | Lookup context identifier |
| lk_size | input | SZ_W | Lookup page-size code |
| lk_hit | output | 1 | Lookup hit; also the useful-prefetch indication |
| lk_ppn | output | PPN_W | Physical page number of the hit entry |
| lk_core | output | CORE_W | Initiator of the hit entry |
| bad_valid | output | 1 | Unused entry evicted this cycle |
| bad_core | output | CORE_W | Initiator of the evicted entry |

## Verification
The lookup removal and the insertion write can land on the same clock edge. The bench provokes this on a full buffer by issuing a hitting lookup and a new-tag insertion together. The result is judged correct when no bad-prefetch pulse appears and the next new-tag insertion evicts the original oldest entry. A second case drives lookup and insertion with one shared tag. Here the lookup must see the old physical page and a later lookup must see the new one with its new initiator.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // How an accepted insertion chooses its slot.
  typedef enum logic [1:0] {
    FILL_FREE    = 2'd0,
    FILL_REFRESH = 2'd1,
    FILL_EVICT   = 2'd2
  } fill_kind_e;

endpackage

// File: rtl/pfb_tag_cmp.sv
module pfb_tag_cmp #(
  parameter int N     = 16,
  parameter int VPN_W = 36,
  parameter int CTX_W = 12,
  parameter int SZ_W  = 2
) (
  input  logic [VPN_W-1:0] tag_vpn  [N],
  input  logic [CTX_W-1:0] tag_ctx  [N],
  input  logic [SZ_W-1:0]  tag_size [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [CTX_W-1:0] key_ctx,
  input  logic [SZ_W-1:0]  key_size,
  output logic [N-1:0]     eq
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (tag_vpn[g] == key_vpn) &&
                   (tag_ctx[g] == key_ctx) &&
                   (tag_size[g] == key_size);
  end

endmodule

// File: rtl/pfb_first_pick.sv
module pfb_first_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // Isolate the lowest set bit.
  assign gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});

endmodule

// File: rtl/pfb_age_order.sv
module pfb_age_order #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] live,
  output logic [N-1:0] oldest
);

  // older_q[i][j] set: slot i was written before slot j.
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (!rst_n || i == j) begin
          older_q[i][j] <= 1'b0;
        end else if (alloc[i]) begin
          older_q[i][j] <= 1'b0;
        end else if (alloc[j]) begin
          older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_old
    always_comb begin
      oldest[gi] = live[gi];
      for (int j = 0; j < N; j++) begin
        if (j != gi && live[j] && !older_q[gi][j]) begin
          oldest[gi] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/xlat_pfbuf.sv
module xlat_pfbuf
  import pfb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int CTX_W   = 12,
  parameter int SZ_W    = 2,
  parameter int PPN_W   = 28,
  parameter int CORE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic [SZ_W-1:0]   ins_size,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [CORE_W-1:0] ins_core,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [SZ_W-1:0]   lk_size,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [CORE_W-1:0] lk_core,
  output logic              bad_valid,
  output logic [CORE_W-1:0] bad_core
);

  // Entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [SZ_W-1:0]    size_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [CORE_W-1:0]  core_q [ENTRIES];
  logic               ready_q;

  logic [ENTRIES-1:0] lk_eq, ins_eq;
  logic [ENTRIES-1:0] hit_mask, live, free_mask, first_free;
  logic [ENTRIES-1:0] ins_match, oldest, tgt, alloc;
  logic               ins_fire;
  fill_kind_e         kind;

  pfb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .SZ_W(SZ_W)) u_lk_cmp (
    .tag_vpn(vpn_q), .tag_ctx(ctx_q), .tag_size(size_q),
    .key_vpn(lk_vpn), .key_ctx(lk_ctx), .key_size(lk_size),
    .eq(lk_eq)
  );

  pfb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .SZ_W(SZ_W)) u_ins_cmp (
    .tag_vpn(vpn_q), .tag_ctx(ctx_q), .tag_size(size_q),
    .key_vpn(ins_vpn), .key_ctx(ins_ctx), .key_size(ins_size),
    .eq(ins_eq)
  );

  // Lookup: same-cycle hit and data
  always_comb begin
    hit_mask = lk_valid ? (lk_eq & valid_q) : '0;
    lk_hit   = |hit_mask;
    lk_ppn   = '0;
    lk_core  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_mask[i]) begin
        lk_ppn  = lk_ppn  | ppn_q[i];
        lk_core = lk_core | core_q[i];
      end
    end
  end

  // Slots that survive this cycle's lookup
  assign live      = valid_q & ~hit_mask;
  assign free_mask = ~live;
  assign ins_match = ins_eq & live;

  pfb_first_pick #(.N(ENTRIES)) u_free_pick (
    .req(free_mask),
    .gnt(first_free)
  );

  pfb_age_order #(.N(ENTRIES)) u_age (
    .clk(clk),
    .rst_n(rst_n),
    .alloc(alloc),
    .live(live),
    .oldest(oldest)
  );

  // Insertion slot choice
  always_comb begin
    if (|ins_match) begin
      kind = FILL_REFRESH;
      tgt  = ins_match;
    end else if (|free_mask) begin
      kind = FILL_FREE;
      tgt  = first_free;
    end else begin
      kind = FILL_EVICT;
      tgt  = oldest;
    end
  end

  assign ins_ready = ready_q;
  assign ins_fire  = ins_valid && ready_q;
  assign alloc     = ins_fire ? tgt : '0;

  // Bad-prefetch feedback for the displaced entry
  always_comb begin
    bad_valid = ins_fire && (kind == FILL_EVICT);
    bad_core  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (bad_valid && tgt[i]) begin
        bad_core = bad_core | core_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      valid_q <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= live | alloc;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vpn_q[g]  <= '0;
        ctx_q[g]  <= '0;
        size_q[g] <= '0;
        ppn_q[g]  <= '0;
        core_q[g] <= '0;
      end else if (alloc[g]) begin
        vpn_q[g]  <= ins_vpn;
        ctx_q[g]  <= ins_ctx;
        size_q[g] <= ins_size;
        ppn_q[g]  <= ins_ppn;
        core_q[g] <= ins_core;
      end
    end
  end

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] hit_mask,
  input logic [ENTRIES-1:0] ins_match,
  input logic               ins_fire,
  input logic               lk_hit,
  input logic               bad_valid
);

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_mask));

  assert_hit_removes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !ins_fire) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));

  assert_fill_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !lk_hit && !(|ins_match) && !(&valid_q))
      |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  assert_evict_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_valid |-> (&valid_q));

  assert_refresh_no_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && |ins_match) |-> !bad_valid);

  assert_refresh_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && |ins_match && !lk_hit) |=> $stable($countones(valid_q)));

  assert_hit_blocks_evict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !bad_valid);

endmodule

bind xlat_pfbuf pfb_checker #(.ENTRIES(ENTRIES)) u_pfb_chk (
  .clk(clk),
  .rst_n(rst_n),
  .valid_q(valid_q),
  .hit_mask(hit_mask),
  .ins_match(ins_match),
  .ins_fire(ins_fire),
  .lk_hit(lk_hit),
  .bad_valid(bad_valid)
);

// File: tb/xlat_pfbuf_test.sv
`timescale 1ns/1ps
module xlat_pfbuf_test;

  localparam int ENTRIES = 16;
  localparam int VPN_W = 36, CTX_W = 12, SZ_W = 2, PPN_W = 28, CORE_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, lk_valid = 1'b0;
  logic ins_ready, lk_hit, bad_valid;
  logic [VPN_W-1:0]  ins_vpn = '0, lk_vpn = '0;
  logic [CTX_W-1:0]  ins_ctx = '0, lk_ctx = '0;
  logic [SZ_W-1:0]   ins_size = '0, lk_size = '0;
  logic [PPN_W-1:0]  ins_ppn = '0, lk_ppn;
  logic [CORE_W-1:0] ins_core = '0, lk_core, bad_core;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  xlat_pfbuf uut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vpn(ins_vpn),
    .ins_ctx(ins_ctx), .ins_size(ins_size), .ins_ppn(ins_ppn), .ins_core(ins_core),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_size(lk_size),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_core(lk_core),
    .bad_valid(bad_valid), .bad_core(bad_core)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: optional insert and optional lookup; outputs sampled mid-cycle.
  logic s_hit, s_bad;
  logic [PPN_W-1:0]  s_ppn;
  logic [CORE_W-1:0] s_core, s_bcore;

  task automatic cycle(input bit iv, input longint iva, input int ictx, input int isz,
                       input longint ippn, input int icore,
                       input bit lv, input longint lva, input int lctx, input int lsz);
    @(negedge clk);
    ins_valid = iv; ins_vpn = VPN_W'(iva); ins_ctx = CTX_W'(ictx); ins_size = SZ_W'(isz);
    ins_ppn = PPN_W'(ippn); ins_core = CORE_W'(icore);
    lk_valid = lv; lk_vpn = VPN_W'(lva); lk_ctx = CTX_W'(lctx); lk_size = SZ_W'(lsz);
    #2;
    s_hit = lk_hit; s_ppn = lk_ppn; s_core = lk_core; s_bad = bad_valid; s_bcore = bad_core;
    @(posedge clk);
    #1;
    ins_valid = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic ins(input longint va, input longint ppn, input int core);
    cycle(1'b1, va, 1, 0, ppn, core, 1'b0, 0, 0, 0);
  endtask

  task automatic look(input longint va);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, va, 1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #2;
    check(ins_ready == 1'b0, "R1 ready low in reset", ins_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(ins_ready == 1'b1, "R1 ready high after reset", ins_ready, 1);
  endtask

  task automatic fill16();
    for (int i = 0; i < ENTRIES; i++) begin
      ins(100 + i, 'h1000 + i, i);
      check(!s_bad, "R6 no eviction while filling", s_bad, 0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    look(100);
    check(!s_hit, "R1 empty after reset", s_hit, 0);
    check(!s_bad, "R1 no bad pulse after reset", s_bad, 0);
  endtask

  task automatic t_match();
    do_reset();
    cycle(1'b1, 50, 3, 1, 'h777, 6, 1'b0, 0, 0, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 50, 4, 1);
    check(!s_hit, "R2 context differs", s_hit, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 50, 3, 2);
    check(!s_hit, "R2 size differs", s_hit, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 51, 3, 1);
    check(!s_hit, "R2 page differs", s_hit, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b0, 50, 3, 1);
    check(!s_hit, "R5 idle lookup no hit", s_hit, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 50, 3, 1);
    check(s_hit, "R2 exact match hits", s_hit, 1);
    check(s_ppn == 'h777, "R3 hit ppn", s_ppn, 'h777);
    check(s_core == 6, "R3 hit initiator", s_core, 6);
    check(!s_bad, "R3 hit no bad pulse", s_bad, 0);
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b1, 50, 3, 1);
    check(!s_hit, "R4 consumed entry gone", s_hit, 0);
  endtask

  task automatic t_handshake();
    do_reset();
    cycle(1'b0, 60, 1, 0, 'h55, 2, 1'b0, 0, 0, 0);
    look(60);
    check(!s_hit, "R10 unaccepted insert not stored", s_hit, 0);
  endtask

  task automatic t_fifo();
    do_reset();
    fill16();
    ins(200, 'h2000, 15);
    check(s_bad, "R7 full insert evicts", s_bad, 1);
    check(s_bcore == 0, "R7 victim initiator oldest", s_bcore, 0);
    ins(101, 'h3101, 9);
    check(!s_bad, "R8 refresh no eviction", s_bad, 0);
    ins(201, 'h2001, 15);
    check(s_bad && s_bcore == 2, "R8 refreshed entry became youngest", s_bcore, 2);
    look(100);
    check(!s_hit, "R7 oldest entry gone", s_hit, 0);
    look(101);
    check(s_hit && s_ppn == 'h3101, "R8 refreshed ppn", s_ppn, 'h3101);
    check(s_core == 9, "R8 refreshed initiator", s_core, 9);
  endtask

  task automatic t_same_cycle();
    do_reset();
    fill16();
    cycle(1'b1, 300, 1, 0, 'h3000, 7, 1'b1, 105, 1, 0);
    check(s_hit && s_core == 5, "R9 hit during insert", s_core, 5);
    check(!s_bad, "R9 no eviction with freed slot", s_bad, 0);
    ins(301, 'h3001, 8);
    check(s_bad && s_bcore == 0, "R9 next insert evicts original oldest", s_bcore, 0);
    cycle(1'b1, 106, 1, 0, 'h4106, 3, 1'b1, 106, 1, 0);
    check(s_hit && s_ppn == 'h1006, "R9 same tag lookup sees old", s_ppn, 'h1006);
    check(!s_bad, "R9 same tag no eviction", s_bad, 0);
    look(106);
    check(s_hit && s_ppn == 'h4106, "R9 same tag new contents", s_ppn, 'h4106);
    check(s_core == 3, "R9 same tag new initiator", s_core, 3);
    look(300);
    check(s_hit && s_ppn == 'h3000, "R9 concurrent insert stored", s_ppn, 'h3000);
  endtask

  initial begin
    t_reset();
    t_match();
    t_handshake();
    t_fifo();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule